// File: doc/BRIEF.md
# CPU Interrupt and Bus-Request Arbiter

This block sits in a CPU control section and decides, at machine-cycle and instruction boundaries, what the processor does next. It can hand the external bus to another master, take a non-maskable interrupt, or take a maskable interrupt in one of three target-forming modes. The instruction sequencer supplies an end-of-machine-cycle pulse and an end-of-instruction pulse. The arbiter answers with bus-grant and tri-state controls, acknowledge-cycle strobes with an automatic wait-state count, and either a restart address or a device-supplied opcode. The interrupt enable flag, the interrupt mode and the vector-base register are kept here, and are written through one-cycle control pulses.

A bus request is looked at on every machine-cycle boundary. Both interrupts are looked at only on instruction boundaries. When several requests meet at the same boundary, the bus request wins, the non-maskable interrupt comes next, and the maskable interrupt comes last. The non-maskable input is edge-sensitive and is remembered until it is serviced. A short reset pulse silences the outputs, but it does not disturb the stored state.

Top module: `irq_bus_arbiter`

## Requirements
- R1: While `rst_n` is low, the outputs are held idle in the same cycle: `bus_oe`=0, `busak_n`=1, `m1_n`=1, `iorq_n`=1, `tgt_valid`=0, `op_valid`=0.
- R2: A reset takes effect only when `rst_n` is sampled low on 3 consecutive rising edges. It then clears the enable flag, clears the vector base to 00h, selects mode 0, ends any grant or acknowledge, and drops a pending non-maskable request. A shorter low pulse leaves all of these unchanged.
- R3: A bus request (`busreq_n`=0) is granted only on a cycle that has `mc_end`=1. From the next cycle, `busak_n`=0 and `bus_oe`=0 (bus tri-stated). The grant holds until `busreq_n` returns high, and it is released in the cycle after that.
- R4: A falling edge on `nmi_n` is latched, even for a one-cycle pulse. At the next `ins_end`, `tgt_valid` pulses for one cycle with `tgt_addr`=0066h, whatever the enable flag holds, and the latch is cleared. A further `ins_end` produces nothing.
- R5: A low `int_n` is accepted only on a cycle with `ins_end`=1 while the enable flag is set. Accepting it clears the flag. With the flag clear, no acknowledge cycle starts.
- R6: When requests meet at one boundary, the order is: bus grant, then the non-maskable interrupt, then the maskable one. Interrupts are not taken during a grant.
- R7: An accepted maskable interrupt runs an acknowledge cycle. `m1_n` and `iorq_n` are both low for exactly 4 cycles (2 base plus 2 automatic waits), starting the cycle after `ins_end`. During those cycles `ack_waits` reads 2, and it reads 0 at all other times. The data byte is sampled in the last of the 4 cycles, and the result appears in the cycle after it.
- R8: In mode 0 (code 2'd0), the result is `op_valid`=1 with `op_code` equal to the sampled data byte, and `tgt_valid` stays 0.
- R9: In mode 1 (code 2'd1), the result is `tgt_addr`=0038h. The data-bus value has no effect on it.
- R10: In mode 2 (code 2'd2), the result is `tgt_addr` = {vector base, sampled data byte}.
- R11: `ei_set` sets the enable flag and `di_clr` clears it. `mode_wr` loads `mode_val`, except that code 2'd3 is ignored. `ivec_wr` loads `ivec_val` into the vector base.
- R12: Taking the non-maskable interrupt also clears the enable flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | CPU reset, active low, synchronous, qualified over 3 cycles |
| mc_end | input | 1 | Pulse on the last cycle of a machine cycle |
| ins_end | input | 1 | Pulse on the last cycle of an instruction (comes with mc_end) |
| busreq_n | input | 1 | External bus request, active low |
| nmi_n | input | 1 | Non-maskable interrupt, falling-edge sensitive |
| int_n | input | 1 | Maskable interrupt request, active low level |
| ei_set | input | 1 | Set the interrupt enable flag |
| di_clr | input | 1 | Clear the interrupt enable flag |
| mode_wr | input | 1 | Write strobe for the interrupt mode |
| mode_val | input | 2 | Mode code: 0, 1 or 2 |
| ivec_wr | input | 1 | Write strobe for the vector base |
| ivec_val | input | 8 | New vector base value |
| data_in | input | 8 | Data-bus byte driven by the interrupting device |
| bus_oe | output | 1 | 1: drive address/data/strobes, 0: tri-state |
| busak_n | output | 1 | Bus acknowledge, active low |
| m1_n | output | 1 | First-cycle marker for the acknowledge cycle, active low |
| iorq_n | output | 1 | I/O request marker for the acknowledge cycle, active low |
| ack_waits | output | 2 | Automatic wait states of the current acknowledge cycle |
| tgt_valid | output | 1 | One-cycle pulse: jump to tgt_addr |
| tgt_addr | output | 16 | Restart or vector address |
| op_valid | output | 1 | One-cycle pulse: execute op_code |
| op_code | output | 8 | Opcode fetched from the data bus in mode 0 |

## Verification
The properties assume that `ins_end` and `mc_end` are low while reset is held. They also assume that a reset shorter than three cycles never lands during a grant or an acknowledge cycle, since either one would resume with no fresh boundary pulse in its past. The directed tests honour both conditions. They release reset only between operations and drive the boundary pulses only after reset has ended. They also keep `ei_set` away from the same cycle as `ins_end`, so that each acceptance is decided by a flag value that is already settled.

// File: rtl/arb_pkg.sv
// Shared types and fixed targets of the interrupt and bus-request arbiter.
package arb_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_GRANT = 2'd1,
        ST_ACK   = 2'd2
    } arb_state_t;

    typedef enum logic [1:0] {
        IM_OPCODE = 2'd0,
        IM_FIXED  = 2'd1,
        IM_TABLE  = 2'd2
    } int_mode_t;

    localparam logic [15:0] NMI_TARGET   = 16'h0066;
    localparam logic [15:0] FIXED_TARGET = 16'h0038;
endpackage

// File: rtl/arb_rst_qual.sv
// Reset qualifier: asserts rst_take once rst_n has been sampled low on
// RST_HOLD consecutive edges, and keeps it asserted while rst_n stays low.
// Assumes rst_n is synchronous to clk.
module arb_rst_qual #(
    parameter int RST_HOLD = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic rst_take
);
    localparam int CW = $clog2(RST_HOLD + 1);
    localparam logic [CW-1:0] LIMIT = CW'(RST_HOLD - 1);

    logic [CW-1:0] low_cnt;

    // Count consecutive low samples, saturating at the limit.
    always_ff @(posedge clk) begin
        if (rst_n) begin
            low_cnt <= '0;
        end else if (low_cnt != LIMIT) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign rst_take = !rst_n && (low_cnt == LIMIT);
endmodule

// File: rtl/arb_nmi_latch.sv
// Non-maskable request latch: catches every falling edge of nmi_n and holds
// it until the sequencer reports that it has been serviced.
// Assumes nmi_n is already synchronous to clk.
module arb_nmi_latch (
    input  logic clk,
    input  logic rst_take,
    input  logic nmi_n,
    input  logic clr,
    output logic pend
);
    logic prev_n;
    logic fall;

    assign fall = prev_n && !nmi_n;

    // Track the previous level and latch a detected edge.
    always_ff @(posedge clk) begin
        if (rst_take) begin
            prev_n <= 1'b1;
            pend   <= 1'b0;
        end else begin
            prev_n <= nmi_n;
            if (fall) begin
                pend <= 1'b1;
            end else if (clr) begin
                pend <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/arb_ctrl_regs.sv
// Interrupt control state: the enable flag, the interrupt mode and the
// vector base. Writes are accepted only while the block runs (run=1).
// Assumes take_any is a one-cycle pulse from the sequencer.
module arb_ctrl_regs
    import arb_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_take,
    input  logic             run,
    input  logic             ei_set,
    input  logic             di_clr,
    input  logic             take_any,
    input  logic             mode_wr,
    input  logic [1:0]       mode_val,
    input  logic             ivec_wr,
    input  logic [VEC_W-1:0] ivec_val,
    output logic             iff_q,
    output int_mode_t        mode_q,
    output logic [VEC_W-1:0] ivec_q
);
    // Enable flag: cleared by reset, by disable, or by taking an interrupt.
    always_ff @(posedge clk) begin
        if (rst_take) begin
            iff_q <= 1'b0;
        end else if (run) begin
            if (take_any || di_clr) begin
                iff_q <= 1'b0;
            end else if (ei_set) begin
                iff_q <= 1'b1;
            end
        end
    end

    // Mode register: the unused code is ignored.
    always_ff @(posedge clk) begin
        if (rst_take) begin
            mode_q <= IM_OPCODE;
        end else if (run && mode_wr && (mode_val != 2'd3)) begin
            mode_q <= int_mode_t'(mode_val);
        end
    end

    // Vector base register.
    always_ff @(posedge clk) begin
        if (rst_take) begin
            ivec_q <= '0;
        end else if (run && ivec_wr) begin
            ivec_q <= ivec_val;
        end
    end
endmodule

// File: rtl/arb_seq.sv
// Boundary sequencer: grants the bus at machine-cycle ends, and takes the
// non-maskable or maskable interrupt at instruction ends, in fixed priority.
// It also runs the acknowledge cycle and forms the target.
// Assumes ins_end is only asserted together with mc_end.
module arb_seq
    import arb_pkg::*;
#(
    parameter int VEC_W     = 8,
    parameter int ADDR_W    = 16,
    parameter int ACK_BASE  = 2,
    parameter int ACK_WAITS = 2
) (
    input  logic              clk,
    input  logic              rst_take,
    input  logic              run,
    input  logic              mc_end,
    input  logic              ins_end,
    input  logic              busreq_n,
    input  logic              int_n,
    input  logic              nmi_pend,
    input  logic              iff_q,
    input  int_mode_t         mode_q,
    input  logic [VEC_W-1:0]  ivec_q,
    input  logic [VEC_W-1:0]  data_in,
    output arb_state_t        state_q,
    output logic              nmi_clr,
    output logic              take_any,
    output logic              tgt_valid_q,
    output logic [ADDR_W-1:0] tgt_addr_q,
    output logic              op_valid_q,
    output logic [VEC_W-1:0]  op_code_q
);
    localparam int ACK_LEN = ACK_BASE + ACK_WAITS;
    localparam int CW      = $clog2(ACK_LEN + 1);
    localparam logic [CW-1:0] ACK_LAST = CW'(ACK_LEN - 1);

    logic [CW-1:0] ack_cnt;
    logic          at_run;
    logic          grant_go;
    logic          nmi_go;
    logic          int_go;

    // Decide at the current boundary, in the fixed priority order.
    assign at_run   = run && (state_q == ST_RUN);
    assign grant_go = at_run && mc_end && !busreq_n;
    assign nmi_go   = at_run && ins_end && nmi_pend && !grant_go;
    assign int_go   = at_run && ins_end && iff_q && !int_n && !grant_go && !nmi_go;
    assign nmi_clr  = nmi_go;
    assign take_any = nmi_go || int_go;

    // State, acknowledge counter and one-cycle result pulses.
    always_ff @(posedge clk) begin
        if (rst_take) begin
            state_q     <= ST_RUN;
            ack_cnt     <= '0;
            tgt_valid_q <= 1'b0;
            tgt_addr_q  <= '0;
            op_valid_q  <= 1'b0;
            op_code_q   <= '0;
        end else begin
            tgt_valid_q <= 1'b0;
            op_valid_q  <= 1'b0;
            case (state_q)
                ST_RUN: begin
                    if (grant_go) begin
                        state_q <= ST_GRANT;
                    end else if (nmi_go) begin
                        tgt_valid_q <= 1'b1;
                        tgt_addr_q  <= ADDR_W'(NMI_TARGET);
                    end else if (int_go) begin
                        state_q <= ST_ACK;
                        ack_cnt <= '0;
                    end
                end
                ST_GRANT: begin
                    if (run && busreq_n) begin
                        state_q <= ST_RUN;
                    end
                end
                ST_ACK: begin
                    if (run) begin
                        ack_cnt <= ack_cnt + 1'b1;
                        if (ack_cnt == ACK_LAST) begin
                            state_q <= ST_RUN;
                            case (mode_q)
                                IM_OPCODE: begin
                                    op_valid_q <= 1'b1;
                                    op_code_q  <= data_in;
                                end
                                IM_TABLE: begin
                                    tgt_valid_q <= 1'b1;
                                    tgt_addr_q  <= ADDR_W'({ivec_q, data_in});
                                end
                                default: begin
                                    tgt_valid_q <= 1'b1;
                                    tgt_addr_q  <= ADDR_W'(FIXED_TARGET);
                                end
                            endcase
                        end
                    end
                end
                default: state_q <= ST_RUN;
            endcase
        end
    end
endmodule

// File: rtl/irq_bus_arbiter.sv
// Top of the interrupt and bus-request arbiter. It ties together the reset
// qualifier, the edge latch, the control registers and the sequencer, and
// gates every output to idle while reset is low.
// Assumes all inputs are synchronous to clk.
module irq_bus_arbiter
    import arb_pkg::*;
#(
    parameter int RST_HOLD  = 3,
    parameter int ACK_BASE  = 2,
    parameter int ACK_WAITS = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mc_end,
    input  logic        ins_end,
    input  logic        busreq_n,
    input  logic        nmi_n,
    input  logic        int_n,
    input  logic        ei_set,
    input  logic        di_clr,
    input  logic        mode_wr,
    input  logic [1:0]  mode_val,
    input  logic        ivec_wr,
    input  logic [7:0]  ivec_val,
    input  logic [7:0]  data_in,
    output logic        bus_oe,
    output logic        busak_n,
    output logic        m1_n,
    output logic        iorq_n,
    output logic [1:0]  ack_waits,
    output logic        tgt_valid,
    output logic [15:0] tgt_addr,
    output logic        op_valid,
    output logic [7:0]  op_code
);
    localparam int VEC_W  = 8;
    localparam int ADDR_W = 16;

    logic       rst_take;
    logic       nmi_pend;
    logic       nmi_clr;
    logic       take_any;
    logic       iff_q;
    int_mode_t  mode_q;
    logic [7:0] ivec_q;
    arb_state_t state_q;
    logic       tgt_valid_q;
    logic       op_valid_q;
    logic       ack_on;

    arb_rst_qual #(.RST_HOLD(RST_HOLD)) u_rst (
        .clk      (clk),
        .rst_n    (rst_n),
        .rst_take (rst_take)
    );

    arb_nmi_latch u_nmi (
        .clk      (clk),
        .rst_take (rst_take),
        .nmi_n    (nmi_n),
        .clr      (nmi_clr),
        .pend     (nmi_pend)
    );

    arb_ctrl_regs #(.VEC_W(VEC_W)) u_regs (
        .clk      (clk),
        .rst_take (rst_take),
        .run      (rst_n),
        .ei_set   (ei_set),
        .di_clr   (di_clr),
        .take_any (take_any),
        .mode_wr  (mode_wr),
        .mode_val (mode_val),
        .ivec_wr  (ivec_wr),
        .ivec_val (ivec_val),
        .iff_q    (iff_q),
        .mode_q   (mode_q),
        .ivec_q   (ivec_q)
    );

    arb_seq #(
        .VEC_W     (VEC_W),
        .ADDR_W    (ADDR_W),
        .ACK_BASE  (ACK_BASE),
        .ACK_WAITS (ACK_WAITS)
    ) u_seq (
        .clk         (clk),
        .rst_take    (rst_take),
        .run         (rst_n),
        .mc_end      (mc_end),
        .ins_end     (ins_end),
        .busreq_n    (busreq_n),
        .int_n       (int_n),
        .nmi_pend    (nmi_pend),
        .iff_q       (iff_q),
        .mode_q      (mode_q),
        .ivec_q      (ivec_q),
        .data_in     (data_in),
        .state_q     (state_q),
        .nmi_clr     (nmi_clr),
        .take_any    (take_any),
        .tgt_valid_q (tgt_valid_q),
        .tgt_addr_q  (tgt_addr),
        .op_valid_q  (op_valid_q),
        .op_code_q   (op_code)
    );

    // Output gating: idle while reset is low, tri-state during a grant.
    assign ack_on    = rst_n && (state_q == ST_ACK);
    assign bus_oe    = rst_n && (state_q != ST_GRANT);
    assign busak_n   = !(rst_n && (state_q == ST_GRANT));
    assign m1_n      = !ack_on;
    assign iorq_n    = !ack_on;
    assign ack_waits = ack_on ? 2'(ACK_WAITS) : 2'd0;
    assign tgt_valid = rst_n && tgt_valid_q;
    assign op_valid  = rst_n && op_valid_q;
endmodule

// File: rtl/irq_bus_arbiter_chk.sv
// Checker for the arbiter's port-level rules, bound into the top module.
// Assumes that no reset shorter than the hold time lands during a grant or
// an acknowledge cycle.
module irq_bus_arbiter_chk (
    input logic clk,
    input logic rst_n,
    input logic mc_end,
    input logic ins_end,
    input logic busreq_n,
    input logic bus_oe,
    input logic busak_n,
    input logic m1_n,
    input logic iorq_n,
    input logic tgt_valid,
    input logic op_valid
);
    // Outputs stay quiet whenever reset is low.
    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RST_QUIET: assert (!bus_oe && busak_n && m1_n && iorq_n && !tgt_valid && !op_valid); // R1
        end
    end

    AST_GRANT_TRISTATE: assert property (@(posedge clk) disable iff (!rst_n)
        !busak_n |-> !bus_oe); // R3

    AST_GRANT_AT_MC_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busak_n) |-> ($past(mc_end) && !$past(busreq_n))); // R3

    AST_ACK_AT_INS_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(iorq_n) |-> $past(ins_end)); // R5

    AST_ACK_MARKED_M1: assert property (@(posedge clk) disable iff (!rst_n)
        !iorq_n |-> !m1_n); // R7

    AST_GRANT_NOT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !(!busak_n && !iorq_n)); // R6

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tgt_valid, op_valid})); // R8

    AST_TGT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid |-> ($past(ins_end) || !$past(iorq_n))); // R4

    AST_OP_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> !$past(iorq_n)); // R8
endmodule

bind irq_bus_arbiter irq_bus_arbiter_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mc_end    (mc_end),
    .ins_end   (ins_end),
    .busreq_n  (busreq_n),
    .bus_oe    (bus_oe),
    .busak_n   (busak_n),
    .m1_n      (m1_n),
    .iorq_n    (iorq_n),
    .tgt_valid (tgt_valid),
    .op_valid  (op_valid)
);

// File: tb/irq_bus_arbiter_bench.sv
// Directed bench for the arbiter: one task per scenario, each checking its results.
module irq_bus_arbiter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mc_end = 1'b0, ins_end = 1'b0;
    logic        busreq_n = 1'b1, nmi_n = 1'b1, int_n = 1'b1;
    logic        ei_set = 1'b0, di_clr = 1'b0, mode_wr = 1'b0, ivec_wr = 1'b0;
    logic [1:0]  mode_val = 2'd0;
    logic [7:0]  ivec_val = 8'h00, data_in = 8'h00;
    logic        bus_oe, busak_n, m1_n, iorq_n, tgt_valid, op_valid;
    logic [1:0]  ack_waits;
    logic [15:0] tgt_addr;
    logic [7:0]  op_code;
    int          n_run = 0, n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    irq_bus_arbiter u_irq_bus_arbiter (
        .clk(clk), .rst_n(rst_n), .mc_end(mc_end), .ins_end(ins_end),
        .busreq_n(busreq_n), .nmi_n(nmi_n), .int_n(int_n),
        .ei_set(ei_set), .di_clr(di_clr), .mode_wr(mode_wr), .mode_val(mode_val),
        .ivec_wr(ivec_wr), .ivec_val(ivec_val), .data_in(data_in),
        .bus_oe(bus_oe), .busak_n(busak_n), .m1_n(m1_n), .iorq_n(iorq_n),
        .ack_waits(ack_waits), .tgt_valid(tgt_valid), .tgt_addr(tgt_addr),
        .op_valid(op_valid), .op_code(op_code)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic boundary(input logic ins);
        mc_end = 1'b1; ins_end = ins;
        tick();
        mc_end = 1'b0; ins_end = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] m);
        mode_val = m; mode_wr = 1'b1; tick(); mode_wr = 1'b0;
    endtask

    task automatic set_ivec(input logic [7:0] v);
        ivec_val = v; ivec_wr = 1'b1; tick(); ivec_wr = 1'b0;
    endtask

    task automatic enable();
        ei_set = 1'b1; tick(); ei_set = 1'b0;
    endtask

    task automatic pulse_nmi();
        nmi_n = 1'b0; tick(); nmi_n = 1'b1;
    endtask

    // Start an acknowledge at an instruction end, check the strobes, and return the result.
    task automatic run_ack(input string req, output logic tv, output logic [15:0] ta,
                           output logic ov, output logic [7:0] oc);
        int_n = 1'b0;
        boundary(1'b1);
        int_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            chk({req, " R7 ack strobes"}, {m1_n, iorq_n}, 2'b00);
            chk({req, " R7 waits"}, ack_waits, 2);
            tick();
        end
        chk({req, " R7 ack ends after 4"}, iorq_n, 1'b1);
        tv = tgt_valid; ta = tgt_addr; ov = op_valid; oc = op_code;
    endtask

    task automatic t_reset();
        logic tv, ov; logic [15:0] ta; logic [7:0] oc;
        rst_n = 1'b0;
        repeat (5) tick();
        chk("R1 quiet outputs", {bus_oe, busak_n, m1_n, iorq_n, tgt_valid, op_valid}, 6'b011100);
        rst_n = 1'b1;
        tick();
        chk("R1 bus driven after reset", bus_oe, 1'b1);
        int_n = 1'b0; boundary(1'b1); int_n = 1'b1;
        chk("R2 flag clear after reset", iorq_n, 1'b1);
        enable();
        data_in = 8'hC7;
        run_ack("R2 mode0 default", tv, ta, ov, oc);
        chk("R8 op_valid", ov, 1'b1);
        chk("R8 no tgt", tv, 1'b0);
        chk("R8 opcode", oc, 8'hC7);
    endtask

    task automatic t_busreq();
        busreq_n = 1'b0;
        tick(); tick();
        chk("R3 no grant without mc_end", busak_n, 1'b1);
        boundary(1'b0);
        chk("R3 grant", {busak_n, bus_oe}, 2'b00);
        tick();
        chk("R3 grant held", busak_n, 1'b0);
        busreq_n = 1'b1;
        tick();
        chk("R3 release", {busak_n, bus_oe}, 2'b11);
    endtask

    task automatic t_nmi();
        enable();
        pulse_nmi();
        tick(); tick();
        boundary(1'b1);
        chk("R4 nmi taken", tgt_valid, 1'b1);
        chk("R4 nmi addr", tgt_addr, 16'h0066);
        tick();
        chk("R4 one pulse", tgt_valid, 1'b0);
        boundary(1'b1);
        chk("R4 latch cleared", tgt_valid, 1'b0);
        int_n = 1'b0; boundary(1'b1); int_n = 1'b1;
        chk("R12 flag cleared by nmi", iorq_n, 1'b1);
        pulse_nmi();
        boundary(1'b1);
        chk("R4 flag ignored", tgt_addr, 16'h0066);
        chk("R4 taken with flag clear", tgt_valid, 1'b1);
    endtask

    task automatic t_iff();
        logic tv, ov; logic [15:0] ta; logic [7:0] oc;
        set_mode(2'd1);
        enable();
        int_n = 1'b0; tick(); tick();
        chk("R5 no accept without ins_end", iorq_n, 1'b1);
        int_n = 1'b1;
        ei_set = 1'b0; di_clr = 1'b1; tick(); di_clr = 1'b0;
        int_n = 1'b0; boundary(1'b1); int_n = 1'b1;
        chk("R11 di blocks", iorq_n, 1'b1);
        enable();
        data_in = 8'h55;
        run_ack("R9 a", tv, ta, ov, oc);
        chk("R9 tgt 0038", {tv, ta}, {1'b1, 16'h0038});
        int_n = 1'b0; boundary(1'b1); int_n = 1'b1;
        chk("R5 flag cleared on accept", iorq_n, 1'b1);
        enable();
        data_in = 8'hAA;
        run_ack("R9 b", tv, ta, ov, oc);
        chk("R9 data ignored", {tv, ov, ta}, {2'b10, 16'h0038});
        set_mode(2'd3);
        enable();
        run_ack("R11 code3", tv, ta, ov, oc);
        chk("R11 code 3 ignored", ta, 16'h0038);
    endtask

    task automatic t_mode2();
        logic tv, ov; logic [15:0] ta; logic [7:0] oc;
        set_mode(2'd2);
        set_ivec(8'h3C);
        enable();
        data_in = 8'h9E;
        run_ack("R10", tv, ta, ov, oc);
        chk("R10 vector", {tv, ta}, {1'b1, 16'h3C9E});
    endtask

    task automatic t_priority();
        logic tv, ov; logic [15:0] ta; logic [7:0] oc;
        set_mode(2'd1);
        enable();
        pulse_nmi();
        busreq_n = 1'b0; int_n = 1'b0;
        boundary(1'b1);
        chk("R6 grant first", {busak_n, iorq_n, tgt_valid}, 3'b010);
        boundary(1'b1);
        chk("R6 no irq in grant", {iorq_n, tgt_valid}, 2'b10);
        busreq_n = 1'b1;
        tick();
        chk("R6 grant released", busak_n, 1'b1);
        boundary(1'b1);
        chk("R6 nmi second", {tgt_valid, tgt_addr}, {1'b1, 16'h0066});
        int_n = 1'b1;
        enable();
        data_in = 8'h12;
        run_ack("R6 int last", tv, ta, ov, oc);
        chk("R6 int last target", {tv, ta}, {1'b1, 16'h0038});
    endtask

    task automatic t_short_reset();
        logic tv, ov; logic [15:0] ta; logic [7:0] oc;
        set_mode(2'd2);
        set_ivec(8'h12);
        enable();
        rst_n = 1'b0; tick(); tick(); rst_n = 1'b1; tick();
        data_in = 8'h34;
        run_ack("R2 short", tv, ta, ov, oc);
        chk("R2 short reset keeps state", {tv, ta}, {1'b1, 16'h1234});
        enable();
        pulse_nmi();
        rst_n = 1'b0; repeat (3) tick(); rst_n = 1'b1; tick();
        int_n = 1'b0; boundary(1'b1); int_n = 1'b1;
        chk("R2 full reset clears flag and nmi", {iorq_n, tgt_valid}, 2'b10);
        set_mode(2'd2);
        enable();
        data_in = 8'h77;
        run_ack("R2 base", tv, ta, ov, oc);
        chk("R2 vector base cleared", ta, 16'h0077);
    endtask

    initial begin
        tick();
        t_reset();
        t_busreq();
        t_nmi();
        t_iff();
        t_mode2();
        t_priority();
        t_short_reset();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule